// File: doc/BRIEF.md
# Trigger Qualifier with Holdoff and Prescalers

This block sits between the raw trigger sources and the timing engine of a delay/pulse generator. It turns an asynchronous external trigger level into clean, clock-aligned trigger strobes. It also merges that source with an internal rate tick and a software single-shot command, and thins the result in two ways. The first is a divide-by-N prescaler on external edges. The second is a holdoff window that throws away any trigger arriving too soon after the previous accepted one. A trigger that arrives while the timing engine reports a cycle in progress is also thrown away.

Each accepted trigger starts one timing cycle. Every output channel has its own prescale counter that advances once per accepted trigger. That counter decides whether the channel is enabled for the cycle, so individual outputs can run at sub-multiples of the trigger rate. A single write strobe restarts every prescale counter, so new divide factors take effect from a known phase.

Top module: `trig_qualifier`

## Requirements
- R1: After reset, `trig_o` and every bit of `out_en_o` are low, and all prescale and holdoff counters start from their first state.
- R2: With `edge_fall_i`=0 a low-to-high transition of `trig_lvl_i` is an external event, and with `edge_fall_i`=1 a high-to-low transition is one. An accepted external event raises `trig_o` for exactly one cycle. This happens after the third rising clock edge following the level change: two synchronizer stages and the output register.
- R3: `src_sel_i` selects the trigger source. Code 0 takes external edges and ignores `rate_tick_i`. Code 1 takes `rate_tick_i` and ignores external edges. Codes 2 and 3 ignore both. An accepted rate tick drives `trig_o` in the cycle after the tick is sampled.
- R4: `shot_i` is a trigger candidate under every `src_sel_i` code. An accepted shot drives `trig_o` in the cycle after it is sampled.
- R5: External events are divided by `trig_div_i` = N. For N ≥ 2, the 1st, (N+1)th, (2N+1)th … events after a restart pass. For N of 0 or 1, every event passes.
- R6: With `holdoff_i` = H ≥ 1, a candidate that comes fewer than H cycles after the previous accepted trigger is discarded, and one that comes exactly H cycles after it is accepted. With H = 0 there is no spacing limit. A discarded candidate does not extend the window.
- R7: A candidate sampled while `busy_i` is high is discarded. It does not start a holdoff window and does not advance any output prescaler.
- R8: Output k is controlled by divide factor M from `out_div_i[k*DIV_W +: DIV_W]`. `out_en_o[k]` pulses together with `trig_o` on the 1st, (M+1)th … accepted triggers after a restart, and on every accepted trigger when M is 0 or 1. It is never high without `trig_o`.
- R9: A high `div_wr_i` resets the trigger prescaler and all output prescalers, so the next event is the first of a new group. An event sampled in the same cycle as the strobe is not passed and not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_lvl_i | input | 1 | Raw external trigger level, asynchronous |
| edge_fall_i | input | 1 | 0: rising edge active, 1: falling edge active |
| src_sel_i | input | 2 | 0 external, 1 rate tick, 2/3 shot only |
| rate_tick_i | input | 1 | Internal rate generator strobe |
| shot_i | input | 1 | Single-shot command strobe |
| busy_i | input | 1 | Timing cycle in progress |
| holdoff_i | input | HOLD_W | Minimum spacing of accepted triggers, in clock cycles |
| trig_div_i | input | DIV_W | External event prescale factor |
| out_div_i | input | N_OUT*DIV_W | Per-output prescale factors, packed |
| div_wr_i | input | 1 | Prescale write strobe, restarts all prescalers |
| trig_o | output | 1 | Accepted-trigger strobe |
| out_en_o | output | N_OUT | Per-output enable for the started cycle |

## Verification
Directed patterns come first, each aimed at one function. Isolated external pulses under each edge polarity show that the active edge is honoured and the opposite edge is ignored. A dense train of external pulses with a divide of three shows whether the prescaler passes the first event of each group. A continuous rate tick under a holdoff of five shows the exact window length, because an off-by-one changes the count of accepted pulses. A busy-held stretch shows that rejected candidates leave no trace. Long random runs then mix all sources, busy, divide factors and mid-group write strobes. These runs are compared cycle by cycle against a bench model, which exposes ordering faults between the prescaler, the holdoff and the busy gate.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    SRC_EXT     = 2'd0,
    SRC_RATE    = 2'd1,
    SRC_MAN     = 2'd2,
    SRC_MAN_ALT = 2'd3
  } src_e;
endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic fall_i,
  output logic edge_o
);
  localparam int DEPTH = SYNC_N + 1;

  logic [DEPTH-1:0] sh_q;
  logic             cur, prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[DEPTH-2:0], lvl_i};
  end

  assign cur    = sh_q[SYNC_N-1];
  assign prev   = sh_q[SYNC_N];
  assign edge_o = fall_i ? (prev & ~cur) : (cur & ~prev);

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> (!edge_o || (fall_i != $past(fall_i)))); // R2
endmodule

// File: rtl/trig_prescale.sv
module trig_prescale #(
  parameter int DIV_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ev_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             pass_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic             unity, wrap;

  assign unity  = (div_i <= ONE);
  assign wrap   = unity || (cnt_q >= div_i - ONE);
  assign pass_o = ev_i & ~clr_i & (unity | (cnt_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (ev_i) cnt_q <= wrap ? '0 : cnt_q + ONE;
  end

  AST_CLR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i && !clr_i && $past(clr_i)) |-> pass_o); // R9
endmodule

// File: rtl/trig_holdoff.sv
module trig_holdoff #(
  parameter int HOLD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cand_i,
  input  logic              busy_i,
  input  logic [HOLD_W-1:0] holdoff_i,
  output logic              accept_o
);
  localparam logic [HOLD_W-1:0] ONE = HOLD_W'(1);

  logic [HOLD_W-1:0] hold_q;
  logic              idle;

  assign idle     = (hold_q == '0);
  assign accept_o = cand_i & ~busy_i & idle;

  // window of H cycles: load H-1 so the candidate H cycles later is taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hold_q <= '0;
    else if (accept_o) hold_q <= (holdoff_i == '0) ? '0 : holdoff_i - ONE;
    else if (!idle)    hold_q <= hold_q - ONE;
  end

  // spacing monitor
  logic [HOLD_W-1:0] gap_q, win_q;
  logic              seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      win_q  <= '0;
      seen_q <= 1'b0;
    end else if (accept_o) begin
      gap_q  <= ONE;
      win_q  <= holdoff_i;
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q  <= gap_q + ONE;
    end
  end

  AST_HOLD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && seen_q) |-> (gap_q >= win_q)); // R6
endmodule

// File: rtl/trig_qualifier.sv
module trig_qualifier #(
  parameter int N_OUT  = 4,
  parameter int DIV_W  = 32,
  parameter int HOLD_W = 24,
  parameter int SYNC_N = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   trig_lvl_i,
  input  logic                   edge_fall_i,
  input  logic [1:0]             src_sel_i,
  input  logic                   rate_tick_i,
  input  logic                   shot_i,
  input  logic                   busy_i,
  input  logic [HOLD_W-1:0]      holdoff_i,
  input  logic [DIV_W-1:0]       trig_div_i,
  input  logic [N_OUT*DIV_W-1:0] out_div_i,
  input  logic                   div_wr_i,
  output logic                   trig_o,
  output logic [N_OUT-1:0]       out_en_o
);
  import trig_pkg::*;

  src_e       src;
  logic       ext_edge, ext_ev, ext_pass, rate_ev, cand, accept;
  logic [N_OUT-1:0] fire;

  assign src = src_e'(src_sel_i);

  trig_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (trig_lvl_i),
    .fall_i (edge_fall_i),
    .edge_o (ext_edge)
  );

  assign ext_ev  = ext_edge & (src == SRC_EXT);
  assign rate_ev = rate_tick_i & (src == SRC_RATE);

  trig_prescale #(.DIV_W(DIV_W)) u_in_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (div_wr_i),
    .ev_i   (ext_ev),
    .div_i  (trig_div_i),
    .pass_o (ext_pass)
  );

  assign cand = ext_pass | rate_ev | shot_i;

  trig_holdoff #(.HOLD_W(HOLD_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cand_i    (cand),
    .busy_i    (busy_i),
    .holdoff_i (holdoff_i),
    .accept_o  (accept)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    trig_prescale #(.DIV_W(DIV_W)) u_out_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (div_wr_i),
      .ev_i   (accept),
      .div_i  (out_div_i[k*DIV_W +: DIV_W]),
      .pass_o (fire[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_o   <= 1'b0;
      out_en_o <= '0;
    end else begin
      trig_o   <= accept;
      out_en_o <= fire;
    end
  end

  AST_EN_NEEDS_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|out_en_o) |-> trig_o); // R8
  AST_BUSY_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !trig_o); // R7
endmodule

// File: tb/trig_qualifier_tb.sv
module trig_qualifier_tb_top;
  localparam int N_OUT  = 4;
  localparam int DIV_W  = 32;
  localparam int HOLD_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_lvl = 1'b0, edge_fall = 1'b0, tick = 1'b0, shot = 1'b0, busy = 1'b0, wr = 1'b0;
  logic [1:0] src = 2'd0;
  logic [HOLD_W-1:0] hold = '0;
  logic [DIV_W-1:0] tdiv = 32'd1;
  logic [N_OUT*DIV_W-1:0] odiv = '0;
  logic trig;
  logic [N_OUT-1:0] en;

  always #10 clk = ~clk;

  trig_qualifier #(.N_OUT(N_OUT), .DIV_W(DIV_W), .HOLD_W(HOLD_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .trig_lvl_i(trig_lvl), .edge_fall_i(edge_fall),
    .src_sel_i(src), .rate_tick_i(tick), .shot_i(shot), .busy_i(busy),
    .holdoff_i(hold), .trig_div_i(tdiv), .out_div_i(odiv), .div_wr_i(wr),
    .trig_o(trig), .out_en_o(en)
  );

  int checks = 0, fails = 0, n_trig = 0;
  string cur_req = "R1";

  // reference model state
  logic m_s1, m_s2, m_s3, exp_trig;
  logic [N_OUT-1:0] exp_en;
  logic [DIV_W-1:0] m_pc;
  logic [DIV_W-1:0] m_oc [N_OUT];
  logic [HOLD_W-1:0] m_hc;

  function automatic logic pass_now(logic [DIV_W-1:0] c, logic [DIV_W-1:0] d);
    return (d <= 1) || (c == 0);
  endfunction

  function automatic logic [DIV_W-1:0] next_cnt(logic [DIV_W-1:0] c, logic [DIV_W-1:0] d);
    return ((d <= 1) || (c >= d - 1)) ? '0 : c + 1;
  endfunction

  always @(posedge clk) begin
    logic ext, pass, cand, acc, f;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pc = 0; m_hc = 0;
      for (int k = 0; k < N_OUT; k++) m_oc[k] = 0;
      exp_trig = 0; exp_en = 0;
    end else begin
      ext = (src == 2'd0) && (edge_fall ? (!m_s2 && m_s3) : (m_s2 && !m_s3));
      pass = 0;
      if (wr) m_pc = 0;
      else if (ext) begin
        pass = pass_now(m_pc, tdiv);
        m_pc = next_cnt(m_pc, tdiv);
      end
      cand = pass || (src == 2'd1 && tick) || shot;
      acc = cand && !busy && (m_hc == 0);
      if (acc) m_hc = (hold == 0) ? '0 : hold - 1;
      else if (m_hc != 0) m_hc = m_hc - 1;
      exp_en = '0;
      for (int k = 0; k < N_OUT; k++) begin
        if (wr) m_oc[k] = 0;
        else if (acc) begin
          f = pass_now(m_oc[k], odiv[k*DIV_W +: DIV_W]);
          exp_en[k] = f;
          m_oc[k] = next_cnt(m_oc[k], odiv[k*DIV_W +: DIV_W]);
        end
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = trig_lvl;
      exp_trig = acc;
    end
  end

  task automatic check_outputs();
    checks++;
    if (trig !== exp_trig || en !== exp_en) begin
      fails++;
      $display("FAIL %s trig_o=%0b exp=%0b out_en_o=%b exp=%b", cur_req, trig, exp_trig, en, exp_en);
    end
    if (trig === 1'b1) n_trig++;
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      check_outputs();
      wr = 0; shot = 0;
    end
  endtask

  task automatic check_count(string req, int got, int want);
    checks++;
    if (got != want) begin
      fails++;
      $display("FAIL %s pulse count=%0d exp=%0d", req, got, want);
    end
  endtask

  task automatic ext_pulses(int n);
    for (int i = 0; i < n; i++) begin
      trig_lvl = 1; tick_n(3);
      trig_lvl = 0; tick_n(3);
    end
  endtask

  task automatic restart();
    wr = 1; tick_n(1);
  endtask

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    cur_req = "R1";
    checks++;
    if (trig !== 1'b0 || en !== '0) begin
      fails++;
      $display("FAIL R1 trig_o=%0b exp=0 out_en_o=%b exp=0", trig, en);
    end
    rst_n = 1;
    tick_n(4);

    // R2 rising and falling edge
    cur_req = "R2";
    n_trig = 0; ext_pulses(3);
    check_count("R2", n_trig, 3);
    edge_fall = 1; n_trig = 0; ext_pulses(2);
    check_count("R2", n_trig, 2);
    edge_fall = 0;

    // R3 source selection
    cur_req = "R3";
    src = 2'd1; n_trig = 0; ext_pulses(2);
    check_count("R3", n_trig, 0);
    tick = 1; tick_n(1); tick = 0; tick_n(3);
    check_count("R3", n_trig, 1);
    src = 2'd2; n_trig = 0; tick = 1; tick_n(4); tick = 0; ext_pulses(2);
    check_count("R3", n_trig, 0);

    // R4 single shot under every source code
    cur_req = "R4";
    n_trig = 0;
    for (int s = 0; s < 4; s++) begin
      src = 2'(s); shot = 1; tick_n(3);
    end
    check_count("R4", n_trig, 4);
    src = 2'd0;

    // R5 prescale by 3, nine edges
    cur_req = "R5";
    tdiv = 3; restart(); n_trig = 0; ext_pulses(9);
    check_count("R5", n_trig, 3);
    tdiv = 0; restart(); n_trig = 0; ext_pulses(4);
    check_count("R5", n_trig, 4);

    // R6 holdoff of 5 against a continuous tick
    cur_req = "R6";
    src = 2'd1; hold = 5; tick_n(8); n_trig = 0;
    tick = 1; tick_n(20); tick = 0; tick_n(6);
    check_count("R6", n_trig, 4);
    hold = 0; n_trig = 0; tick = 1; tick_n(6); tick = 0; tick_n(2);
    check_count("R6", n_trig, 6);

    // R7 busy blocks everything
    cur_req = "R7";
    busy = 1; n_trig = 0; tick = 1; tick_n(10); shot = 1; tick_n(1); tick = 0; tick_n(2);
    busy = 0;
    check_count("R7", n_trig, 0);

    // R8 per-output prescalers 1,2,3,0
    cur_req = "R8";
    odiv = {32'd0, 32'd3, 32'd2, 32'd1}; restart();
    for (int i = 0; i < 7; i++) begin tick = 1; tick_n(1); tick = 0; tick_n(2); end

    // R9 restart in the middle of a group
    cur_req = "R9";
    src = 2'd0; tdiv = 4; restart(); ext_pulses(2);
    restart(); n_trig = 0; ext_pulses(1);
    check_count("R9", n_trig, 1);
    trig_lvl = 1; tick_n(2); wr = 1; tick_n(1); tick_n(3); trig_lvl = 0; tick_n(3);

    // random mix
    cur_req = "R5";
    for (int seg = 0; seg < 20; seg++) begin
      cur_req = (seg % 2 == 0) ? "R6" : "R8";
      src = 2'($urandom_range(0, 3));
      edge_fall = 1'($urandom_range(0, 1));
      hold = HOLD_W'($urandom_range(0, 7));
      tdiv = 32'($urandom_range(0, 4));
      for (int k = 0; k < N_OUT; k++) odiv[k*DIV_W +: DIV_W] = 32'($urandom_range(0, 4));
      restart();
      for (int c = 0; c < 200; c++) begin
        if ($urandom_range(0, 2) == 0) trig_lvl = ~trig_lvl;
        tick  = ($urandom_range(0, 3) == 0);
        shot  = ($urandom_range(0, 30) == 0);
        busy  = ($urandom_range(0, 5) == 0);
        wr    = ($urandom_range(0, 60) == 0);
        tick_n(1);
      end
      tick = 0; busy = 0;
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule